// File: doc/BRIEF.md
# Key Matrix Column Scanner

This block scans a matrix of push keys arranged as a few drive columns and eight sense rows. Every sense row has a pull-up, so an idle row reads 1. A pressed key pulls its row low only while its column is driven low. The scanner drives the column lines active low and reads the rows back through a synchronizer. It inverts the row data and masks it with a set of wanted keys, so that a pressed key shows up as a 1 bit.

Each scan pass starts with a quick check that drives every column low at once. The scanner steps through the columns one at a time only when that check finds a wanted key. It stops at the lowest-numbered column that shows a key and reports that column together with its row bits in a single-cycle event. Once an event is accepted, the scanner stays locked and produces no further events. It unlocks only after the keyboard has read released for a programmable number of clock cycles without a break. A held key therefore produces one event, and contact bounce cannot produce repeated events.

Top module: `keypad_scanner`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cols_o` is all zeros (the all-columns check), `key_valid_o` is 0, and `key_col_o` and `key_bits_o` are 0.
- R2: `cols_o` is active low, and bit c drives column c. The only patterns ever driven are all zeros (all-columns check), exactly one zero (single-column step), and all ones (gap).
- R3: Each scan step holds its column pattern for DWELL = SYNC_STAGES+1 cycles, then drives all ones for one gap cycle. A step with no key found lasts DWELL+1 cycles, so an idle scanner repeats the all-columns check every DWELL+1 cycles.
- R4: `rows_i` passes through SYNC_STAGES flip-flops before use. A step samples in its last drive cycle, and the value it sees is `rows_i` as driven in the step's first cycle. The column pattern has been stable for at least one cycle before the sample.
- R5: The hit vector is the bitwise NOT of the synchronized rows ANDed with `key_mask_i` taken in the sample cycle. Bit r of `key_bits_o` is row r.
- R6: Single-column steps start only after an all-columns check finds a hit while the scanner is unlocked. They go from column 0 upward and stop at the first column with a hit, which is reported. If no column shows a hit, scanning returns to the all-columns check.
- R7: `key_valid_o` is a one-cycle pulse in the cycle after the column step's sample cycle. `key_col_o` and `key_bits_o` carry that column index and hit vector, and they keep their values until the next event.
- R8: After an event the scanner is locked. While locked it runs only all-columns checks, and any check with a hit restarts the release count. It unlocks after RELEASE_CYCLES consecutive cycles with no such hit, so a key held down yields exactly one event.
- R9: A pressed key whose bit in `key_mask_i` is 0 produces no event and does not restart the release count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rows_i | input | NUM_ROWS | Row sense lines with pull-ups; 0 = key conducting |
| key_mask_i | input | NUM_ROWS | 1 = row bit is a wanted key |
| cols_o | output | NUM_COLS | Column drive, active low |
| key_valid_o | output | 1 | One-cycle event strobe |
| key_col_o | output | COL_W | Column index of the reported key |
| key_bits_o | output | NUM_ROWS | Inverted, masked row bits of the reported column |

## Verification
The column drive is due in the cycle its step begins, and it is compared in every cycle. A row level that is set up during a step's first drive cycle reaches the decision SYNC_STAGES cycles later, in the step's sample cycle. The resulting event pulse appears one cycle after that sample cycle. The bench carries these delays with a queue of row values as long as the synchronizer. It updates its model on the rising edge and compares on the falling edge, so every expected value is taken in the exact cycle where the design must produce it. Directed checks then count the events seen during press, hold, bounce and masked-key windows. Each window is longer than the worst-case scan latency of five steps.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
   typedef enum logic {
      SCAN_ALL = 1'b0,
      SCAN_ONE = 1'b1
   } scan_mode_e;
endpackage

// File: rtl/keyscan_sync.sv
module keyscan_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("keyscan_sync: STAGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/keyscan_sequencer.sv
module keyscan_sequencer
   import keyscan_pkg::*;
#(
   parameter int NUM_COLS = 3,
   parameter int NUM_ROWS = 8,
   parameter int DWELL    = 3,
   localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
   localparam int PH_W    = $clog2(DWELL + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_ROWS-1:0] rows_sync_i,
   input  logic [NUM_ROWS-1:0] key_mask_i,
   input  logic                armed_i,
   output logic [NUM_COLS-1:0] cols_o,
   output logic                any_hit_o,
   output logic                accept_o,
   output logic [COL_W-1:0]    accept_col_o,
   output logic [NUM_ROWS-1:0] accept_bits_o
);
   logic [PH_W-1:0]     phase_q;
   scan_mode_e          mode_q, mode_nxt_q;
   logic [COL_W-1:0]    col_q, col_nxt_q;
   logic                sample_en, gap, last_col, hit;
   logic [NUM_ROWS-1:0] hit_vec;

   generate
      if (DWELL < 2) begin : g_bad_dwell
         $error("keyscan_sequencer: DWELL must be at least 2");
      end
   endgenerate

   assign sample_en = (phase_q == PH_W'(DWELL - 1));
   assign gap       = (phase_q == PH_W'(DWELL));
   assign last_col  = (col_q == COL_W'(NUM_COLS - 1));
   assign hit_vec   = ~rows_sync_i & key_mask_i;
   assign hit       = |hit_vec;

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col_drive
      assign cols_o[c] = gap ? 1'b1
                       : (mode_q == SCAN_ALL) ? 1'b0
                       : (col_q != COL_W'(c));
   end

   assign any_hit_o     = sample_en && (mode_q == SCAN_ALL) && hit;
   assign accept_o      = sample_en && (mode_q == SCAN_ONE) && hit;
   assign accept_col_o  = col_q;
   assign accept_bits_o = hit_vec;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q    <= '0;
         mode_q     <= SCAN_ALL;
         col_q      <= '0;
         mode_nxt_q <= SCAN_ALL;
         col_nxt_q  <= '0;
      end else begin
         if (gap) begin
            phase_q <= '0;
            mode_q  <= mode_nxt_q;
            col_q   <= col_nxt_q;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
         if (sample_en) begin
            if (mode_q == SCAN_ALL) begin
               if (hit && armed_i) begin
                  mode_nxt_q <= SCAN_ONE;
                  col_nxt_q  <= '0;
               end else begin
                  mode_nxt_q <= SCAN_ALL;
               end
            end else if (hit || last_col) begin
               mode_nxt_q <= SCAN_ALL;
            end else begin
               mode_nxt_q <= SCAN_ONE;
               col_nxt_q  <= col_q + 1'b1;
            end
         end
      end
   end

   // R2: drive is all low, a single low column, or all high
   a_r2_col_pattern: assert property (@(posedge clk) disable iff (rst)
      ($countones(~cols_o) <= 1) || (cols_o == '0));

   // R3: any change to a driven pattern passes through the all-high gap
   a_r3_gap_between_steps: assert property (@(posedge clk) disable iff (rst)
      ((cols_o != $past(cols_o)) && (cols_o != '1)) |-> ($past(cols_o) == '1));

   // R4: drive was stable at least one cycle before the rows are sampled
   a_r4_stable_before_sample: assert property (@(posedge clk) disable iff (rst)
      sample_en |-> $stable(cols_o));

   // R6: a single-column step never follows the last column
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (gap && mode_q == SCAN_ONE && last_col) |=> (mode_q == SCAN_ALL));
endmodule

// File: rtl/keyscan_release.sv
module keyscan_release #(
   parameter int RELEASE_CYCLES = 1000000,
   localparam int CNT_W = $clog2(RELEASE_CYCLES)
) (
   input  logic clk,
   input  logic rst,
   input  logic accept_i,
   input  logic any_hit_i,
   output logic armed_o
);
   logic             locked_q;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (RELEASE_CYCLES < 2) begin : g_bad_release
         $error("keyscan_release: RELEASE_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         locked_q <= 1'b0;
         cnt_q    <= '0;
      end else if (accept_i) begin
         locked_q <= 1'b1;
         cnt_q    <= '0;
      end else if (locked_q) begin
         if (any_hit_i) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_W'(RELEASE_CYCLES - 1)) begin
            locked_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign armed_o = ~locked_q;

   // R8: a hit seen while locked keeps the lock for the next cycle
   a_r8_hit_keeps_lock: assert property (@(posedge clk) disable iff (rst)
      (locked_q && any_hit_i) |=> locked_q);

   // R8: an accepted event always locks
   a_r8_accept_locks: assert property (@(posedge clk) disable iff (rst)
      accept_i |=> !armed_o);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
   parameter int NUM_COLS       = 3,
   parameter int NUM_ROWS       = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int RELEASE_CYCLES = 1000000,
   localparam int COL_W         = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
   localparam int DWELL         = SYNC_STAGES + 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_ROWS-1:0] rows_i,
   input  logic [NUM_ROWS-1:0] key_mask_i,
   output logic [NUM_COLS-1:0] cols_o,
   output logic                key_valid_o,
   output logic [COL_W-1:0]    key_col_o,
   output logic [NUM_ROWS-1:0] key_bits_o
);
   logic [NUM_ROWS-1:0] rows_sync;
   logic                armed, any_hit, accept;
   logic [COL_W-1:0]    acc_col;
   logic [NUM_ROWS-1:0] acc_bits;
   logic                valid_q;
   logic [COL_W-1:0]    col_q;
   logic [NUM_ROWS-1:0] bits_q;

   generate
      if (NUM_COLS < 2) begin : g_bad_cols
         $error("keypad_scanner: NUM_COLS must be at least 2");
      end
      if (NUM_ROWS < 1) begin : g_bad_rows
         $error("keypad_scanner: NUM_ROWS must be at least 1");
      end
   endgenerate

   keyscan_sync #(.WIDTH(NUM_ROWS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (rows_i),
      .q_o (rows_sync)
   );

   keyscan_sequencer #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .DWELL(DWELL)) u_seq (
      .clk           (clk),
      .rst           (rst),
      .rows_sync_i   (rows_sync),
      .key_mask_i    (key_mask_i),
      .armed_i       (armed),
      .cols_o        (cols_o),
      .any_hit_o     (any_hit),
      .accept_o      (accept),
      .accept_col_o  (acc_col),
      .accept_bits_o (acc_bits)
   );

   keyscan_release #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_rel (
      .clk       (clk),
      .rst       (rst),
      .accept_i  (accept),
      .any_hit_i (any_hit),
      .armed_o   (armed)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         col_q   <= '0;
         bits_q  <= '0;
      end else begin
         valid_q <= accept;
         if (accept) begin
            col_q  <= acc_col;
            bits_q <= acc_bits;
         end
      end
   end

   assign key_valid_o = valid_q;
   assign key_col_o   = col_q;
   assign key_bits_o  = bits_q;

   // R7: the event strobe lasts exactly one cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      key_valid_o |=> !key_valid_o);

   // R7: a reported event always carries at least one key bit
   a_r7_bits_present: assert property (@(posedge clk) disable iff (rst)
      key_valid_o |-> (key_bits_o != '0));

   // R8: no event is accepted while the release lock is held
   a_r8_no_accept_locked: assert property (@(posedge clk) disable iff (rst)
      accept |-> armed);

   // R7: reported column lies inside the matrix
   a_r7_col_range: assert property (@(posedge clk) disable iff (rst)
      key_valid_o |-> (key_col_o < COL_W'(NUM_COLS)));
endmodule

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
   localparam int NC   = 3;
   localparam int NR   = 8;
   localparam int SS   = 2;
   localparam int REL  = 40;
   localparam int DW   = SS + 1;
   localparam int CW   = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NR-1:0] rows_i;
   logic [NR-1:0] key_mask_i = '1;
   logic [NC-1:0] cols_o;
   logic          key_valid_o;
   logic [CW-1:0] key_col_o;
   logic [NR-1:0] key_bits_o;

   logic [NR-1:0] keys [NC];

   int vectors = 0;
   int fails   = 0;
   int events  = 0;
   int last_col = 0;
   int last_bits = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   keypad_scanner #(.NUM_COLS(NC), .NUM_ROWS(NR), .SYNC_STAGES(SS),
                    .RELEASE_CYCLES(REL)) uut (
      .clk (clk), .rst (rst), .rows_i (rows_i), .key_mask_i (key_mask_i),
      .cols_o (cols_o), .key_valid_o (key_valid_o),
      .key_col_o (key_col_o), .key_bits_o (key_bits_o));

   function automatic logic [NR-1:0] matrix(input logic [NC-1:0] drive);
      logic [NR-1:0] r = '1;
      for (int c = 0; c < NC; c++) if (!drive[c]) r = r & ~keys[c];
      return r;
   endfunction

   always_comb rows_i = matrix(cols_o);

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: behaviour of the scan, held in integers and a queue
   int m_phase, m_all, m_col, m_nall, m_ncol, m_lock, m_cnt;
   int m_valid, m_kcol, m_kbits;
   logic [NR-1:0] rq [$];

   function automatic logic [NC-1:0] m_cols();
      if (m_phase == DW) return '1;
      if (m_all != 0) return '0;
      return ~(NC'(1) << m_col);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_phase = 0; m_all = 1; m_col = 0; m_nall = 1; m_ncol = 0;
         m_lock = 0; m_cnt = 0; m_valid = 0; m_kcol = 0; m_kbits = 0;
         rq.delete();
         for (int i = 0; i < SS; i++) rq.push_back('1);
      end else begin
         logic [NR-1:0] seen, hv;
         int acc, anyh;
         seen = rq.pop_front();
         rq.push_back(matrix(m_cols()));
         acc = 0; anyh = 0;
         hv = ~seen & key_mask_i;
         if (m_phase == DW - 1) begin
            if (m_all != 0) begin
               anyh = (hv != 0);
               if (anyh != 0 && m_lock == 0) begin m_nall = 0; m_ncol = 0; end
               else m_nall = 1;
            end else if (hv != 0) begin
               acc = 1; m_nall = 1;
            end else if (m_col == NC - 1) m_nall = 1;
            else begin m_nall = 0; m_ncol = m_col + 1; end
         end
         m_valid = acc;
         if (acc != 0) begin m_kcol = m_col; m_kbits = int'(hv); end
         if (acc != 0) begin m_lock = 1; m_cnt = 0; end
         else if (m_lock != 0) begin
            if (anyh != 0) m_cnt = 0;
            else if (m_cnt == REL - 1) begin m_lock = 0; m_cnt = 0; end
            else m_cnt++;
         end
         if (m_phase == DW) begin m_phase = 0; m_all = m_nall; m_col = m_ncol; end
         else m_phase++;
      end
   end

   // every-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!rst && !finished) begin
         check("R2/R3 cols", int'(cols_o), int'(m_cols()));
         check("R7 valid", int'(key_valid_o), m_valid);
         check("R6 col", int'(key_col_o), m_kcol);
         check("R5 bits", int'(key_bits_o), m_kbits);
         if (key_valid_o) begin
            events++; last_col = int'(key_col_o); last_bits = int'(key_bits_o);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic release_all();
      for (int c = 0; c < NC; c++) keys[c] = '0;
   endtask

   initial begin
      release_all();
      rst = 1'b1;
      idle(4);
      // R1: reset state
      check("R1 cols in reset", int'(cols_o), 0);
      check("R1 valid in reset", int'(key_valid_o), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 cols after reset", int'(cols_o), 0);
      check("R1 bits after reset", int'(key_bits_o), 0);
      idle(20);
      check("R6 no event when idle", events, 0);

      // R5/R6/R7: single key column 1 row 3
      keys[1] = 8'h08;
      idle(40);
      check("R7 one event", events, 1);
      check("R6 column", last_col, 1);
      check("R5 bits", last_bits, 8'h08);
      // R8: held key gives a single event
      idle(150);
      check("R8 held key single event", events, 1);

      // R8: short release (bounce) keeps the lock
      release_all();
      idle(20);
      keys[1] = 8'h08;
      idle(60);
      check("R8 bounce ignored", events, 1);
      release_all();
      idle(80);
      keys[2] = 8'h20;
      idle(40);
      check("R8 re-armed event", events, 2);
      check("R6 column 2", last_col, 2);
      check("R5 bits row 5", last_bits, 8'h20);
      release_all();
      idle(80);

      // R9: masked key ignored
      key_mask_i = 8'hEF;
      keys[0] = 8'h10;
      idle(80);
      check("R9 masked key no event", events, 2);
      keys[0] = 8'h04;
      idle(40);
      check("R9 unmasked key after masked", events, 3);
      check("R5 bits row 2", last_bits, 8'h04);
      release_all();
      key_mask_i = 8'hFF;
      idle(80);

      // R6: two columns pressed, lowest reported
      keys[0] = 8'h04; keys[2] = 8'h40;
      idle(40);
      check("R6 lowest column wins", last_col, 0);
      check("R6 lowest column bits", last_bits, 8'h04);
      check("R6 one event two cols", events, 4);
      release_all();
      idle(80);

      // R5: two rows in one column
      keys[1] = 8'h81;
      idle(40);
      check("R5 two rows", last_bits, 8'h81);
      check("R6 column of two rows", last_col, 1);
      release_all();
      idle(80);
      check("R8 total events", events, 5);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule